// File: doc/BRIEF.md
# Spindle Run/Stop Sequencer with Ready Qualification

This block keeps the control flags that take a disk spindle from running to stopped. A run flag follows a run request. When run drops, because the request was released or because an abort arrived, a registered edge detector raises an end-of-run flag. That flag walks the stop sequence in a fixed order. The sequence-control flag is first forced set if it was clear, so the sequence always starts from the same state. The sequence-control flag is then cleared and the brake-enable flag is raised on the same clock edge. Brake-enable stays high for a parameterised number of timing ticks. When the window ends, brake-enable and end-of-run clear together.

A ready signal is formed from the sequence-control flag, the heads-loaded status and an internal emergency flag. That flag is set by an abort and blocks any restart of run. Ready is ANDed with the drive-select input to give selected-and-ready, which gates the interface drivers and receivers. A delayed-ready output follows selected-and-ready but holds its falling edge for a parameterised number of clock cycles.

Top module: `spin_seq_top`

## Requirements
- R1: After reset, run_o, eor_o, seq_o, brake_o, ready_o, sel_rdy_o and dly_rdy_o are all 0.
- R2: With no stop sequence in progress and no emergency latched, run_o goes to 1 on the first clock edge that samples run_req_i=1. It goes to 0 on the first edge that samples run_req_i=0.
- R3: An edge that samples abort_i=1 clears run_o whatever run_req_i is, and latches the emergency flag. While that flag is set, run_o stays 0. The flag clears on an edge that samples run_req_i=0 with no stop sequence in progress. After that, run can be requested again.
- R4: eor_o goes to 1 one clock edge after the edge at which run_o fell. It stays 1 until the edge that ends the braking window.
- R5: An edge that samples run_o=1 and start_done_i=1 sets seq_o. If eor_o=1, seq_o=0 and brake_o=0, the next edge forces seq_o to 1.
- R6: On the edge after eor_o=1 and seq_o=1 are seen together with brake_o=0, seq_o clears and brake_o sets. seq_o and brake_o are never 1 together.
- R7: brake_o stays 1 until the edge that samples the BRAKE_TICKS-th tick_i pulse seen while braking. At that edge brake_o and eor_o both clear.
- R8: While a stop sequence is in progress, run_req_i has no effect on run_o. A sequence is in progress from the edge after run falls until brake_o clears.
- R9: ready_o equals seq_o AND heads_ok_i AND NOT emergency. It changes in the same cycle as its inputs.
- R10: sel_rdy_o equals ready_o AND select_i, with no added latency.
- R11: dly_rdy_o is 1 whenever sel_rdy_o is 1. After an edge that samples sel_rdy_o=1 and is followed by sel_rdy_o=0, dly_rdy_o stays 1 until the HOLD_CYCLES-th later edge, then falls. A new high on sel_rdy_o restarts the full hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_req_i | input | 1 | Level run request |
| abort_i | input | 1 | Emergency abort request |
| heads_ok_i | input | 1 | Heads loaded status |
| select_i | input | 1 | Drive selected |
| tick_i | input | 1 | Sequence timing tick, one cycle wide |
| start_done_i | input | 1 | Spin-up complete pulse |
| run_o | output | 1 | Run flag |
| eor_o | output | 1 | End-of-run flag |
| seq_o | output | 1 | Sequence-control flag |
| brake_o | output | 1 | Brake-enable flag |
| ready_o | output | 1 | Ready |
| sel_rdy_o | output | 1 | Selected and ready |
| dly_rdy_o | output | 1 | Delayed ready, trailing edge held |

## Verification
The flags are registered and each stop step costs exactly one edge. Run falls at the stop edge E, end-of-run rises at E+1, and a forced sequence-control set takes E+2. Brake then rises one edge after both end-of-run and sequence-control are seen. The brake window ends at the edge that samples the final tick. Ready and selected-and-ready are combinational, so they are checked one time step after the inputs change, inside the same cycle. The bench drives inputs 1 ns after each rising edge and samples after the next edge plus 1 ns. Each expected value therefore comes from an exact count of edges since the stimulus. For delayed-ready, the bench counts edges from the last edge that saw selected-and-ready high, and expects the fall at exactly HOLD_CYCLES edges.

// File: rtl/spin_pkg.sv
package spin_pkg;
  typedef struct packed {
    logic run;
    logic eor;
    logic seq;
    logic brake;
  } spin_flags_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/spin_run_ctrl.sv
module spin_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  input  logic abort_i,
  input  logic busy_i,
  output logic run_o,
  output logic fall_o,
  output logic emerg_o
);
  logic run_q, run_prev_q, emerg_q;
  logic stop_busy;

  assign fall_o    = run_prev_q & ~run_q;
  assign stop_busy = busy_i | fall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      run_prev_q <= 1'b0;
      emerg_q    <= 1'b0;
    end else begin
      run_prev_q <= run_q;
      if (abort_i || !run_req_i)                         run_q <= 1'b0;
      else if (!run_q && !stop_busy && !emerg_q)         run_q <= 1'b1;
      if (abort_i)                                       emerg_q <= 1'b1;
      else if (emerg_q && !run_req_i && !stop_busy)      emerg_q <= 1'b0;
    end
  end

  assign run_o   = run_q;
  assign emerg_o = emerg_q;

  // R8
  run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(!stop_busy && !emerg_q));

  // R3
  abort_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!run_q && emerg_q));
endmodule

// File: rtl/spin_stop_seq.sv
module spin_stop_seq #(
  parameter int unsigned BRAKE_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fall_i,
  input  logic start_done_i,
  input  logic tick_i,
  output logic eor_o,
  output logic seq_o,
  output logic brake_o
);
  localparam int unsigned CW = spin_pkg::cnt_w(BRAKE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(BRAKE_TICKS - 1);

  logic eor_q, seq_q, brake_q;
  logic [CW-1:0] tick_cnt_q;
  logic brake_end, preset, hand_off;

  assign brake_end = brake_q & tick_i & (tick_cnt_q == LAST);
  assign preset    = eor_q & ~seq_q & ~brake_q;
  assign hand_off  = eor_q &  seq_q & ~brake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eor_q      <= 1'b0;
      seq_q      <= 1'b0;
      brake_q    <= 1'b0;
      tick_cnt_q <= '0;
    end else begin
      if (fall_i)         eor_q <= 1'b1;
      else if (brake_end) eor_q <= 1'b0;

      if (preset)                     seq_q <= 1'b1;
      else if (hand_off)              seq_q <= 1'b0;
      else if (run_i && start_done_i) seq_q <= 1'b1;

      if (hand_off)       brake_q <= 1'b1;
      else if (brake_end) brake_q <= 1'b0;

      if (!brake_q || brake_end) tick_cnt_q <= '0;
      else if (tick_i)           tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  assign eor_o   = eor_q;
  assign seq_o   = seq_q;
  assign brake_o = brake_q;

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_q && brake_q));

  // R5
  seq_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eor_q && !seq_q && !brake_q) |=> seq_q);

  // R6
  brake_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brake_q) |-> $past(eor_q && seq_q));

  // R7
  brake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brake_q) |-> ($fell(eor_q) && $past(tick_i)));
endmodule

// File: rtl/spin_ready.sv
module spin_ready #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_i,
  input  logic heads_ok_i,
  input  logic emerg_i,
  input  logic select_i,
  output logic ready_o,
  output logic sel_rdy_o,
  output logic dly_rdy_o
);
  localparam int unsigned HW = spin_pkg::cnt_w(HOLD_CYCLES);

  assign ready_o   = seq_i & heads_ok_i & ~emerg_i;
  assign sel_rdy_o = ready_o & select_i;

  generate
    if (HOLD_CYCLES == 0) begin : g_nohold
      assign dly_rdy_o = sel_rdy_o;
    end else begin : g_hold
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           hold_q <= '0;
        else if (sel_rdy_o)    hold_q <= HW'(HOLD_CYCLES);
        else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      end
      assign dly_rdy_o = sel_rdy_o | (hold_q != '0);

      // R11
      trail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sel_rdy_o) |-> dly_rdy_o);
    end
  endgenerate
endmodule

// File: rtl/spin_seq_top.sv
module spin_seq_top #(
  parameter int unsigned BRAKE_TICKS = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  input  logic abort_i,
  input  logic heads_ok_i,
  input  logic select_i,
  input  logic tick_i,
  input  logic start_done_i,
  output logic run_o,
  output logic eor_o,
  output logic seq_o,
  output logic brake_o,
  output logic ready_o,
  output logic sel_rdy_o,
  output logic dly_rdy_o
);
  spin_pkg::spin_flags_t flags;
  logic fall, emerg;

  spin_run_ctrl u_run (
    .clk_i, .rst_ni, .run_req_i, .abort_i,
    .busy_i  (flags.eor | flags.brake),
    .run_o   (flags.run),
    .fall_o  (fall),
    .emerg_o (emerg)
  );

  spin_stop_seq #(.BRAKE_TICKS(BRAKE_TICKS)) u_stop (
    .clk_i, .rst_ni,
    .run_i        (flags.run),
    .fall_i       (fall),
    .start_done_i,
    .tick_i,
    .eor_o        (flags.eor),
    .seq_o        (flags.seq),
    .brake_o      (flags.brake)
  );

  spin_ready #(.HOLD_CYCLES(HOLD_CYCLES)) u_rdy (
    .clk_i, .rst_ni,
    .seq_i      (flags.seq),
    .heads_ok_i,
    .emerg_i    (emerg),
    .select_i,
    .ready_o,
    .sel_rdy_o,
    .dly_rdy_o
  );

  assign run_o   = flags.run;
  assign eor_o   = flags.eor;
  assign seq_o   = flags.seq;
  assign brake_o = flags.brake;

  // R4
  eor_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags.run) |=> flags.eor);

  // R10
  sel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rdy_o |-> (select_i && ready_o && heads_ok_i));
endmodule

// File: tb/sim_spin_seq_top.sv
`timescale 1ns/1ps
module sim_spin_seq_top;
  localparam int unsigned BT = 3;
  localparam int unsigned HC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 0, abort = 0, heads = 0, sel = 0, tick = 0, sdone = 0;
  logic run, eor, seq, brake, ready, srdy, drdy;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spin_seq_top #(.BRAKE_TICKS(BT), .HOLD_CYCLES(HC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_req_i(run_req), .abort_i(abort),
    .heads_ok_i(heads), .select_i(sel), .tick_i(tick), .start_done_i(sdone),
    .run_o(run), .eor_o(eor), .seq_o(seq), .brake_o(brake),
    .ready_o(ready), .sel_rdy_o(srdy), .dly_rdy_o(drdy)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    run_req = 0; abort = 0; heads = 0; sel = 0; tick = 0; sdone = 0;
    rst_n = 0; #7; rst_n = 1;
    cyc();
  endtask

  task automatic scenario(input bit s, input bit a, input int p);
    do_reset();
    heads = 1;
    run_req = 1; cyc();
    chk("R2", "run up", run, 1'b1);
    if (s) begin
      sdone = 1; cyc(); sdone = 0;
      chk("R5", "seq from start", seq, 1'b1);
      chk("R9", "ready", ready, 1'b1);
    end
    if (a) abort = 1; else run_req = 0;
    cyc(); abort = 0;
    chk(a ? "R3" : "R2", "run down", run, 1'b0);
    chk("R4", "eor not yet", eor, 1'b0);
    if (a) chk("R9", "ready blocked by emergency", ready, 1'b0);
    cyc();
    chk("R4", "eor set", eor, 1'b1);
    chk("R5", "seq held", seq, s);
    chk("R8", "run ignored", run, 1'b0);
    if (!s) begin
      cyc();
      chk("R5", "seq forced", seq, 1'b1);
      chk("R6", "no brake yet", brake, 1'b0);
    end
    cyc();
    chk("R6", "seq cleared", seq, 1'b0);
    chk("R6", "brake set", brake, 1'b1);
    run_req = 1;
    for (int k = 0; k < int'(BT); k++) begin
      for (int i = 0; i < p - 1; i++) begin
        cyc();
        chk("R7", "brake hold", brake, 1'b1);
        chk("R4", "eor hold", eor, 1'b1);
        chk("R8", "run held off", run, 1'b0);
      end
      tick = 1; cyc(); tick = 0;
      chk("R7", "brake after tick", brake, k < int'(BT) - 1);
      chk("R7", "eor after tick", eor, k < int'(BT) - 1);
      chk("R8", "run held off", run, 1'b0);
    end
    cyc();
    if (!a) begin
      chk("R2", "restart", run, 1'b1);
    end else begin
      chk("R3", "emergency blocks", run, 1'b0);
      run_req = 0; cyc();
      run_req = 1; cyc();
      chk("R3", "restart after release", run, 1'b1);
    end
  endtask

  initial begin
    #50000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1", "run", run, 1'b0); chk("R1", "eor", eor, 1'b0);
    chk("R1", "seq", seq, 1'b0); chk("R1", "brake", brake, 1'b0);
    chk("R1", "ready", ready, 1'b0); chk("R1", "srdy", srdy, 1'b0);
    chk("R1", "drdy", drdy, 1'b0);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 2; a++)
        for (int p = 1; p <= 2; p++)
          scenario(s[0], a[0], p);

    // ready / select sweep
    do_reset();
    run_req = 1; cyc();
    sdone = 1; cyc(); sdone = 0;
    for (int h = 0; h < 2; h++)
      for (int q = 0; q < 2; q++) begin
        heads = h[0]; sel = q[0]; #1;
        chk("R9", "ready sweep", ready, h[0]);
        chk("R10", "srdy sweep", srdy, h[0] & q[0]);
        if (h[0] & q[0]) chk("R11", "drdy rise", drdy, 1'b1);
      end
    // trailing hold, then retrigger mid-hold
    for (int r = 0; r < 2; r++) begin
      heads = 1; sel = 1; cyc(); cyc();
      sel = 0; #1;
      chk("R11", "drdy hold start", drdy, 1'b1);
      if (r == 0) begin
        cyc(); cyc();
        chk("R11", "drdy mid", drdy, 1'b1);
        sel = 1; #1;
        chk("R11", "drdy retrig", drdy, 1'b1);
        cyc(); sel = 0; #1;
      end
      for (int k = 1; k <= int'(HC); k++) begin
        cyc();
        chk("R11", "drdy trail", drdy, k < int'(HC));
        chk("R10", "srdy low", srdy, 1'b0);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule